// File: doc/BRIEF.md
# Serial Audio Receiver with Word-Width Adaptation

This block takes a two-channel serial audio stream in which another device drives the bit clock, the frame clock and the data line. It turns that stream into parallel left/right sample pairs of a fixed internal width. The three serial lines are brought into the system clock domain through short synchronizer chains. Every rising edge of the bit clock is then treated as one bit event, and the data and frame clock lines are taken at that event.

The word boundary is set by the frame clock alone. The bit position counter starts again on every frame clock transition. Because of this, a transmitted word of any length stays correctly placed. Three alignments are supported: the classic two-channel format, in which the frame clock changes one bit before the MSB; MSB-first alignment on the frame clock edge; and LSB-last alignment against the next edge. A longer word loses its low-order bits. A shorter word gets zeros appended below its LSB, which keeps a two's complement value at the right scale.

Once a left word and the right word that follows it are both complete, the pair appears on registered outputs together with a one-cycle strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is high and in the cycle after it, `valid_o` is 0 and both sample outputs are all zeros.
- R2: A bit event is a rising edge of `sck_in` seen after synchronization, and `sd_in` and `ws_in` are taken at that event. A word sent while the frame clock is 0 is the left sample; a word sent while it is 1 is the right sample.
- R3: With `fmt` = 0 (classic alignment), the MSB is the second bit event after a frame clock change, and a word ends with the first bit event after the following change.
- R4: With `fmt` = 1 (MSB-first alignment), the MSB is the first bit event after a frame clock change, and a word ends at the last bit event before the next change.
- R5: With `fmt` = 2 (LSB-last alignment), the word is the `rj_len` bits that arrive last before a frame clock change, MSB first.
- R6: If a word is longer than OUT_W bits, only its OUT_W most significant bits are kept.
- R7: If a word is shorter than OUT_W bits, it fills the upper part of the output and the unused low bits are zero.
- R8: `valid_o` is high for exactly one cycle after each right word completes. At that point `left_o` holds the left word of the same frame and `right_o` holds that right word.
- R9: After reset, the partial word in progress is dropped, as is any right word that has no complete left word before it. No strobe is produced for either.
- R10: Slot lengths may change from one half-frame to the next. In the MSB-first modes, bits past the OUT_W-th bit of a slot have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which must be well above the bit clock rate |
| rst | input | 1 | Synchronous active-high reset |
| fmt | input | 2 | Alignment select: 0 classic, 1 MSB-first, 2 LSB-last |
| rj_len | input | $clog2(HIST_W+1) | Word length used in LSB-last mode |
| sck_in | input | 1 | Bit clock from the external master |
| ws_in | input | 1 | Frame clock: 0 for left, 1 for right |
| sd_in | input | 1 | Serial data, MSB first |
| left_o | output | OUT_W | Left sample of the last completed pair |
| right_o | output | OUT_W | Right sample of the last completed pair |
| valid_o | output | 1 | One-cycle strobe for a new pair |

## Verification
The bench uses OUT_W = 16, HIST_W = 32 and two synchronizer stages. With these values, 24-bit and 32-bit words exercise low-bit truncation, while 8-bit and 12-bit words exercise zero fill. Slots of 32 and 48 bits drive the position counter into saturation, so the excess trailing bits can be shown to have no effect. LSB-last words of 24 bits in 32-bit slots, and of 12 bits in 16-bit slots, fit inside the 32-bit history register. Together they check both directions of the width adaptation in that mode.

// File: rtl/serin_pkg.sv
package serin_pkg;

    // Alignment of the data word relative to the frame clock.
    typedef enum logic [1:0] {
        FMT_CLASSIC = 2'd0,
        FMT_MSB     = 2'd1,
        FMT_LSB     = 2'd2,
        FMT_RSV     = 2'd3
    } fmt_e;

    // One bit event taken from the serial lines.
    typedef struct packed {
        logic ws;
        logic sd;
    } bit_ev_t;

    // Channel codes carried by the frame clock level.
    localparam logic CH_LEFT  = 1'b0;
    localparam logic CH_RIGHT = 1'b1;

    // The classic format runs one bit late with respect to the frame clock.
    function automatic logic lags_frame(input fmt_e f);
        return f == FMT_CLASSIC;
    endfunction

endpackage

// File: rtl/serin_sync.sv
module serin_sync
    import serin_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sck_in,
    input  logic    ws_in,
    input  logic    sd_in,
    output logic    bit_stb,
    output bit_ev_t bit_ev
);
    localparam int LINES = 3;
    localparam int L_SD  = 0;
    localparam int L_WS  = 1;
    localparam int L_SCK = 2;

    logic [LINES-1:0]             raw;
    logic [LINES-1:0][STAGES-1:0] chain;
    logic                         sck_prev;

    assign raw = {sck_in, ws_in, sd_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            chain    <= '0;
            sck_prev <= 1'b0;
        end else begin
            for (int i = 0; i < LINES; i++) begin
                chain[i] <= {chain[i][STAGES-2:0], raw[i]};
            end
            sck_prev <= chain[L_SCK][STAGES-1];
        end
    end

    assign bit_stb   = chain[L_SCK][STAGES-1] & ~sck_prev;
    assign bit_ev.ws = chain[L_WS][STAGES-1];
    assign bit_ev.sd = chain[L_SD][STAGES-1];

    // A rising edge is a single-cycle event.
    assert_stb_single_R2: assert property (@(posedge clk) disable iff (rst)
        bit_stb |=> !bit_stb);

endmodule

// File: rtl/serin_framer.sv
module serin_framer
    import serin_pkg::*;
#(
    parameter int OUT_W = 16,
    localparam int PW   = $clog2(OUT_W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  fmt_e          fmt,
    input  logic          bit_stb,
    input  bit_ev_t       bit_ev,
    output logic          fin,
    output logic          chan,
    output logic          started,
    output logic [PW-1:0] pos,
    output logic          bnd
);
    logic          ws_d1;
    logic          ws_eff;
    logic          ws_last;
    logic [PW-1:0] cnt;

    assign ws_eff = lags_frame(fmt) ? ws_d1 : bit_ev.ws;
    assign bnd    = bit_stb && (ws_eff != ws_last);
    assign fin    = bnd;
    assign chan   = ws_last;
    assign pos    = bnd ? '0 : cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ws_d1   <= 1'b0;
            ws_last <= 1'b0;
            cnt     <= '0;
            started <= 1'b0;
        end else if (bit_stb) begin
            ws_d1   <= bit_ev.ws;
            ws_last <= ws_eff;
            if (bnd) begin
                cnt     <= PW'(1);
                started <= 1'b1;
            end else if (cnt != PW'(OUT_W)) begin
                cnt <= cnt + PW'(1);
            end
        end
    end

    // The position counter restarts on every frame clock transition.
    assert_cnt_restart_R10: assert property (@(posedge clk) disable iff (rst)
        bnd |=> (cnt == PW'(1)));

    // Once started, the flag stays set until reset.
    assert_started_hold_R9: assert property (@(posedge clk) disable iff (rst)
        started |=> started);

endmodule

// File: rtl/serin_shifter.sv
module serin_shifter
    import serin_pkg::*;
#(
    parameter int OUT_W  = 16,
    parameter int HIST_W = 32,
    localparam int PW    = $clog2(OUT_W + 1),
    localparam int LW    = $clog2(HIST_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  fmt_e             fmt,
    input  logic [LW-1:0]    rj_len,
    input  logic             bit_stb,
    input  logic             bnd,
    input  logic [PW-1:0]    pos,
    input  logic             dbit,
    output logic [OUT_W-1:0] word
);
    logic [OUT_W-1:0]  acc;
    logic [HIST_W-1:0] hist;
    logic [LW-1:0]     len_c;
    logic [HIST_W-1:0] hist_al;
    logic [OUT_W-1:0]  rj_word;

    // MSB-first assembly: the word is cleared at each boundary, and its
    // bits are written from the top down until OUT_W bits have been placed.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (bit_stb) begin
            if (bnd) begin
                acc          <= '0;
                acc[OUT_W-1] <= dbit;
            end else begin
                for (int i = 0; i < OUT_W; i++) begin
                    if (pos == PW'(OUT_W - 1 - i)) begin
                        acc[i] <= dbit;
                    end
                end
            end
        end
    end

    // Running history of the most recent bits, newest in bit 0.
    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else if (bit_stb) begin
            hist <= {hist[HIST_W-2:0], dbit};
        end
    end

    // LSB-last extraction: move the MSB of the last rj_len bits to the top.
    // The bits shifted in below are zeros, which supplies the fill.
    assign len_c   = (rj_len > LW'(HIST_W)) ? LW'(HIST_W) : rj_len;
    assign hist_al = hist << (LW'(HIST_W) - len_c);
    assign rj_word = hist_al[HIST_W-1 -: OUT_W];

    assign word = (fmt == FMT_LSB) ? rj_word : acc;

    // Bits beyond the output width in MSB-first modes leave the word unchanged.
    assert_excess_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && !bnd && pos == PW'(OUT_W)) |=> $stable(acc));

endmodule

// File: rtl/serin_pair.sv
module serin_pair
    import serin_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fin,
    input  logic             started,
    input  logic             chan,
    input  logic [OUT_W-1:0] word,
    output logic [OUT_W-1:0] left_o,
    output logic [OUT_W-1:0] right_o,
    output logic             valid_o
);
    logic [OUT_W-1:0] left_hold;
    logic             have_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_hold <= '0;
            have_left <= 1'b0;
            left_o    <= '0;
            right_o   <= '0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (fin && started) begin
                if (chan == CH_LEFT) begin
                    left_hold <= word;
                    have_left <= 1'b1;
                end else if (have_left) begin
                    left_o    <= left_hold;
                    right_o   <= word;
                    valid_o   <= 1'b1;
                    have_left <= 1'b0;
                end
            end
        end
    end

    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    assert_no_orphan_R9: assert property (@(posedge clk) disable iff (rst)
        (fin && chan == CH_RIGHT && !have_left) |=> !valid_o);

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import serin_pkg::*;
#(
    parameter int OUT_W       = 16,
    parameter int HIST_W      = 32,
    parameter int SYNC_STAGES = 2,
    localparam int PW         = $clog2(OUT_W + 1),
    localparam int LW         = $clog2(HIST_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       fmt,
    input  logic [LW-1:0]    rj_len,
    input  logic             sck_in,
    input  logic             ws_in,
    input  logic             sd_in,
    output logic [OUT_W-1:0] left_o,
    output logic [OUT_W-1:0] right_o,
    output logic             valid_o
);
    fmt_e             fmt_q;
    logic             bit_stb;
    bit_ev_t          bit_ev;
    logic             fin;
    logic             chan;
    logic             started;
    logic             bnd;
    logic [PW-1:0]    pos;
    logic [OUT_W-1:0] word;

    assign fmt_q = fmt_e'(fmt);

    serin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .sck_in  (sck_in),
        .ws_in   (ws_in),
        .sd_in   (sd_in),
        .bit_stb (bit_stb),
        .bit_ev  (bit_ev)
    );

    serin_framer #(.OUT_W(OUT_W)) u_framer (
        .clk     (clk),
        .rst     (rst),
        .fmt     (fmt_q),
        .bit_stb (bit_stb),
        .bit_ev  (bit_ev),
        .fin     (fin),
        .chan    (chan),
        .started (started),
        .pos     (pos),
        .bnd     (bnd)
    );

    serin_shifter #(.OUT_W(OUT_W), .HIST_W(HIST_W)) u_shifter (
        .clk     (clk),
        .rst     (rst),
        .fmt     (fmt_q),
        .rj_len  (rj_len),
        .bit_stb (bit_stb),
        .bnd     (bnd),
        .pos     (pos),
        .dbit    (bit_ev.sd),
        .word    (word)
    );

    serin_pair #(.OUT_W(OUT_W)) u_pair (
        .clk     (clk),
        .rst     (rst),
        .fin     (fin),
        .started (started),
        .chan    (chan),
        .word    (word),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o)
    );

    // R1: the cycle after reset shows the cleared outputs.
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (!valid_o && left_o == '0 && right_o == '0));

endmodule

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;
    localparam int OW = 16;
    localparam int HW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    fmt = 2'd0;
    logic [5:0]    rj_len = 6'd0;
    logic          sck = 1'b0;
    logic          ws = 1'b0;
    logic          sd = 1'b0;
    logic [OW-1:0] left_o, right_o;
    logic          valid_o;

    int errs = 0;
    int checks = 0;
    string tag = "R1";
    logic [OW-1:0] expl_q[$];
    logic [OW-1:0] expr_q[$];
    logic          bq[$];
    logic          tq[$];
    logic [OW-1:0] el, er;

    always #2 clk = ~clk;

    serial_audio_rx #(.OUT_W(OW), .HIST_W(HW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .fmt(fmt), .rj_len(rj_len),
        .sck_in(sck), .ws_in(ws), .sd_in(sd),
        .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
    );

    function automatic logic [OW-1:0] expw(input logic [31:0] w, input int len);
        logic [31:0] t;
        if (len >= OW) t = w >> (len - OW);
        else           t = w << (OW - len);
        return t[OW-1:0];
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Scoreboard monitor: every strobe is matched against the expected queue.
    always @(negedge clk) begin
        if (!rst && valid_o) begin
            if (expl_q.size() == 0) begin
                checks++;
                errs++;
                $display("FAIL R8/R9 [%s]: actual=unexpected strobe expected=none", tag);
            end else begin
                el = expl_q.pop_front();
                er = expr_q.pop_front();
                chk({tag, " R2 left"}, 32'(left_o), 32'(el));
                chk({tag, " R2 right"}, 32'(right_o), 32'(er));
            end
        end
    end

    task automatic add_half(input logic ch, input logic [31:0] w, input int len,
                            input int slot, input logic lsb_last);
        for (int p = 0; p < slot; p++) begin
            logic b;
            if (!lsb_last) b = (p < len) ? w[len-1-p] : 1'b0;
            else           b = (p >= slot - len) ? w[slot-1-p] : 1'b0;
            bq.push_back(b);
            tq.push_back(ch);
        end
    endtask

    task automatic frame(input logic [31:0] l, input logic [31:0] r, input int len, input int slot);
        add_half(1'b0, l, len, slot, fmt == 2'd2);
        add_half(1'b1, r, len, slot, fmt == 2'd2);
        expl_q.push_back(expw(l, len));
        expr_q.push_back(expw(r, len));
    endtask

    task automatic drive_bit(input logic w, input logic d);
        @(negedge clk);
        sck = 1'b0;
        ws  = w;
        sd  = d;
        repeat (3) @(negedge clk);
        sck = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic play();
        int n;
        n = bq.size();
        for (int j = 0; j < n; j++) begin
            logic wv;
            // Classic format: the frame clock changes one bit ahead of the data.
            wv = (fmt == 2'd0 && j + 1 < n) ? tq[j+1] : tq[j];
            drive_bit(wv, bq[j]);
        end
        bq.delete();
        tq.delete();
    endtask

    task automatic start(input string t, input logic [1:0] f, input logic [5:0] rl, input bit prime);
        tag = t;
        @(negedge clk);
        rst = 1'b1;
        fmt = f;
        rj_len = rl;
        sck = 1'b0;
        ws = 1'b0;
        sd = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 reset valid", 32'(valid_o), 32'd0);
        chk("R1 reset left", 32'(left_o), 32'd0);
        chk("R1 reset right", 32'(right_o), 32'd0);
        rst = 1'b0;
        if (prime) add_half(1'b1, 32'd0, 4, 4, 1'b0);
    endtask

    task automatic finish();
        add_half(1'b0, 32'd0, 4, 4, 1'b0);
        play();
        repeat (20) @(negedge clk);
        checks++;
        if (expl_q.size() != 0) begin
            errs++;
            $display("FAIL R8 [%s]: actual=%0d pairs missing expected=0", tag, expl_q.size());
            expl_q.delete();
            expr_q.delete();
        end
    endtask

    initial begin
        // R3 classic alignment, exact, truncated (R6) and filled (R7) words
        start("R3", 2'd0, 6'd0, 1'b1);
        frame(32'h8001, 32'h7ffe, 16, 16);
        frame(32'hA5C3F1, 32'h3C0F96, 24, 32);
        frame(32'h9A5, 32'h0F3, 12, 16);
        frame(32'hDEADBEEF, 32'h12345678, 32, 32);
        finish();

        // R4 MSB-first alignment
        start("R4", 2'd1, 6'd0, 1'b1);
        frame(32'hC3A5, 32'h5A3C, 16, 32);
        frame(32'h812345, 32'h7FEDCB, 24, 24);
        frame(32'hB7, 32'h4C, 8, 16);
        finish();

        // R5 LSB-last alignment, longer word (R6)
        start("R5", 2'd2, 6'd24, 1'b1);
        frame(32'hF0E1D2, 32'h0A1B2C, 24, 32);
        frame(32'h876543, 32'h13579B, 24, 32);
        finish();

        // R5 LSB-last alignment, shorter word (R7)
        start("R7", 2'd2, 6'd12, 1'b1);
        frame(32'h801, 32'h7FF, 12, 16);
        frame(32'hABC, 32'h123, 12, 32);
        finish();

        // R10 slot length changes mid-stream; trailing bits past OUT_W ignored
        start("R10", 2'd1, 6'd0, 1'b1);
        frame(32'h1234, 32'hFEDC, 16, 16);
        add_half(1'b0, 32'h8765, 16, 48, 1'b0);
        for (int k = 16; k < 48; k++) bq[bq.size()-48+k] = k[0];
        add_half(1'b1, 32'h4321, 16, 20, 1'b0);
        expl_q.push_back(16'h8765);
        expr_q.push_back(16'h4321);
        frame(32'hCAFEF00D, 32'h0BADBEEF, 32, 48);
        finish();

        // R9 partial words after reset are dropped: only the last pair emerges
        start("R9", 2'd1, 6'd0, 1'b0);
        add_half(1'b0, 32'h1111, 16, 16, 1'b0);
        add_half(1'b1, 32'h2222, 16, 16, 1'b0);
        frame(32'h3333, 32'h4444, 16, 16);
        finish();

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog [%s]: actual=timeout expected=completion", tag);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule